// File: doc/BRIEF.md
# Processor Status Trace Encoder

This block sits beside a simple in-order core and turns the core's per-cycle execution events into a 5-bit status code stream, with a 4-bit debug nibble port (plus a valid flag) that carries data and address payloads. Each cycle the core may raise strobes for an ordinary instruction start, a continuation cycle of a multi-cycle instruction, a taken branch (with its target), a program-counter sync that has been serviced, a return from exception, entry into user mode, a marker instruction (optionally of the kind that writes an operand to the debug port), and a captured bus transfer. Two control inputs enable branch-target capture and bus-data capture.

Sequential ordinary instructions are not reported one by one. They are counted, and the run is reported as a single code carrying its length. It is flushed when it reaches sixteen instructions or when any other event has to be reported. Every payload is announced by a size code and then goes out one nibble per cycle, least significant first. An event that arrives while a payload is still going out waits in a single holding slot and is reported right after the last nibble.

All outputs are registered: a strobe sampled at a clock edge shows its first code right after that edge. The reset is asynchronous on assertion and released through a two-stage synchronizer.

Top module: `trace_status_encoder`

## Requirements
- R1: While reset is active and after it, with no events, the status code is 0x00 and the nibble valid flag is 0.
- R2: Idle cycles and continuation strobes show code 0x00. A run of N sequential ordinary-instruction strobes (1 ≤ N ≤ 16) shows 0x00 while it accumulates and yields exactly one code 0x10+N-1. The run is reported right after the strobe that brings it to 16 instructions, which shows 0x1F.
- R3: A non-sequential event presented while a run is pending first shows the run code, and its own code follows one cycle later.
- R4: A taken branch or a serviced sync shows 0x05. With branch capture on, a taken branch is followed next cycle by 0x0D and 4 nibbles of target[16:1] when br_wide=0, or by 0x0E and 6 nibbles of target[23:1] when br_wide=1. A sync, or a branch with capture off, sends no payload.
- R5: A return from exception shows 0x07, and entry into user mode shows 0x03, each right after the edge that samples its strobe.
- R6: A marker instruction shows 0x04. If mark_write=1, the next cycle shows a size code and then the operand nibbles. mark_size 0 gives 0x08 and 2 nibbles, 1 gives 0x09 and 4 nibbles, 2 or 3 gives 0x0B and 8 nibbles. With mark_write=0 there is no payload.
- R7: With data capture on, a bus strobe shows its size code directly (same size encoding as R6), followed by bus_data nibbles. With data capture off, a bus strobe has no effect on either output.
- R8: Payload nibbles start the cycle after the size code and go out least significant first, one per cycle, with the valid flag high and the status code at 0x00.
- R9: One event presented while a payload is going out is reported in the cycle right after the last nibble.
- R10: When several strobes arrive together, only one is taken, in this order: marker, taken branch, sync, return from exception, user mode, bus data (if enabled), ordinary instruction. The others are dropped.
- R11: The codes 0x02, 0x06, 0x0A, 0x0C and 0x0F are never shown.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_branch_en | input | 1 | Enable branch-target address payloads |
| cfg_data_en | input | 1 | Enable bus-data capture |
| ev_insn | input | 1 | Ordinary instruction starts this cycle |
| ev_cont | input | 1 | Extra cycle of a multi-cycle instruction |
| ev_branch | input | 1 | Taken branch |
| br_target | input | ADDR_W (24) | Branch target address |
| br_wide | input | 1 | Send 3-byte (1) or 2-byte (0) address |
| ev_sync | input | 1 | Program-counter sync request serviced |
| ev_xret | input | 1 | Return from exception starts |
| ev_user | input | 1 | Core has entered user mode |
| ev_mark | input | 1 | Marker instruction starts |
| mark_write | input | 1 | Marker carries an operand for the debug port |
| mark_size | input | 2 | Operand size: 0 byte, 1 word, 2/3 longword |
| mark_data | input | DATA_W (32) | Operand value |
| ev_bus | input | 1 | Bus transfer captured |
| bus_size | input | 2 | Bus transfer size, same encoding as mark_size |
| bus_data | input | DATA_W (32) | Bus transfer value |
| status_code | output | 5 | Processor status code |
| dbg_nib | output | 4 | Debug payload nibble |
| dbg_nib_vld | output | 1 | Debug nibble valid |

## Verification
On every cycle the assertions check that no reserved code appears, that the status code stays at 0x00 while nibbles are valid, and that every size code is followed at once by a valid nibble. They also check that nibble streams begin only right after a size code, and that both outputs stay quiet during reset. Run lengths, flush ordering, the exact nibble values and order, the per-size byte counts, gating by the two capture controls, priority among simultaneous strobes, and the delayed report of a held event depend on specific stimulus, so only the bench's directed scenarios show them.

// File: rtl/trace_enc_pkg.sv
package trace_enc_pkg;

  localparam int TRC_PAY_W = 32;
  localparam int TRC_CNT_W = 4;

  localparam logic [4:0] C_CONT  = 5'h00;
  localparam logic [4:0] C_INSN  = 5'h01;
  localparam logic [4:0] C_USER  = 5'h03;
  localparam logic [4:0] C_MARK  = 5'h04;
  localparam logic [4:0] C_FLOW  = 5'h05;
  localparam logic [4:0] C_XRET  = 5'h07;
  localparam logic [4:0] C_D1    = 5'h08;
  localparam logic [4:0] C_D2    = 5'h09;
  localparam logic [4:0] C_D4    = 5'h0B;
  localparam logic [4:0] C_A2    = 5'h0D;
  localparam logic [4:0] C_A3    = 5'h0E;
  localparam logic [4:0] C_RUN   = 5'h10;

  typedef enum logic [1:0] {ST_CODE, ST_MARK, ST_NIB} enc_state_e;

  typedef struct packed {
    logic                 valid;
    logic                 seq;
    logic [4:0]           code;
    logic                 has_mark;
    logic [4:0]           mark;
    logic [TRC_CNT_W-1:0] nnib;
    logic [TRC_PAY_W-1:0] payload;
  } trace_ev_t;

  function automatic logic [4:0] size_code(input logic [1:0] sz);
    case (sz)
      2'd0:    size_code = C_D1;
      2'd1:    size_code = C_D2;
      default: size_code = C_D4;
    endcase
  endfunction

  function automatic logic [TRC_CNT_W-1:0] size_nibs(input logic [1:0] sz);
    case (sz)
      2'd0:    size_nibs = TRC_CNT_W'(2);
      2'd1:    size_nibs = TRC_CNT_W'(4);
      default: size_nibs = TRC_CNT_W'(8);
    endcase
  endfunction

endpackage

// File: rtl/trace_rst_sync.sv
module trace_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/trace_event_decode.sv
module trace_event_decode
  import trace_enc_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int DATA_W = TRC_PAY_W
) (
  input  logic              cfg_branch_en,
  input  logic              cfg_data_en,
  input  logic              ev_insn,
  input  logic              ev_branch,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              br_wide,
  input  logic              ev_sync,
  input  logic              ev_xret,
  input  logic              ev_user,
  input  logic              ev_mark,
  input  logic              mark_write,
  input  logic [1:0]        mark_size,
  input  logic [DATA_W-1:0] mark_data,
  input  logic              ev_bus,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  output trace_ev_t         ev_o
);
  localparam int NIB_NARROW = 4;
  localparam int NIB_WIDE   = 6;

  // Fixed priority: marker, branch, sync, xret, user, bus, instruction
  always_comb begin
    ev_o = '0;
    if (ev_mark) begin
      ev_o.valid = 1'b1;
      ev_o.code  = C_MARK;
      if (mark_write) begin
        ev_o.has_mark = 1'b1;
        ev_o.mark     = size_code(mark_size);
        ev_o.nnib     = size_nibs(mark_size);
        ev_o.payload  = TRC_PAY_W'(mark_data);
      end
    end else if (ev_branch) begin
      ev_o.valid = 1'b1;
      ev_o.code  = C_FLOW;
      if (cfg_branch_en) begin
        ev_o.has_mark = 1'b1;
        ev_o.mark     = br_wide ? C_A3 : C_A2;
        ev_o.nnib     = br_wide ? TRC_CNT_W'(NIB_WIDE) : TRC_CNT_W'(NIB_NARROW);
        ev_o.payload  = TRC_PAY_W'(br_target >> 1);
      end
    end else if (ev_sync) begin
      ev_o.valid = 1'b1;
      ev_o.code  = C_FLOW;
    end else if (ev_xret) begin
      ev_o.valid = 1'b1;
      ev_o.code  = C_XRET;
    end else if (ev_user) begin
      ev_o.valid = 1'b1;
      ev_o.code  = C_USER;
    end else if (ev_bus && cfg_data_en) begin
      ev_o.valid   = 1'b1;
      ev_o.code    = size_code(bus_size);
      ev_o.nnib    = size_nibs(bus_size);
      ev_o.payload = TRC_PAY_W'(bus_data);
    end else if (ev_insn) begin
      ev_o.valid = 1'b1;
      ev_o.seq   = 1'b1;
      ev_o.code  = C_INSN;
    end
  end
endmodule

// File: rtl/trace_nib_shift.sv
module trace_nib_shift #(
  parameter int W  = 32,
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [W-1:0]  load_val,
  input  logic [CW-1:0] load_cnt,
  input  logic          adv,
  output logic [3:0]    nib_o,
  output logic          last_o
);
  logic [W-1:0]  sh_q, sh_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          en;

  always_comb begin
    sh_n  = sh_q;
    cnt_n = cnt_q;
    if (load) begin
      sh_n  = load_val;
      cnt_n = load_cnt;
    end else if (adv) begin
      sh_n  = sh_q >> 4;
      cnt_n = cnt_q - CW'(1);
    end
  end

  assign en = load | adv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= '0;
    end else if (en) begin
      sh_q  <= sh_n;
      cnt_q <= cnt_n;
    end
  end

  assign nib_o  = sh_q[3:0];
  assign last_o = (cnt_q == CW'(1));
endmodule

// File: rtl/trace_status_encoder.sv
module trace_status_encoder
  import trace_enc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int DATA_W   = TRC_PAY_W,
  parameter int RUN_MAX  = 16,
  parameter bit COMPRESS = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_branch_en,
  input  logic              cfg_data_en,
  input  logic              ev_insn,
  input  logic              ev_cont,
  input  logic              ev_branch,
  input  logic [ADDR_W-1:0] br_target,
  input  logic              br_wide,
  input  logic              ev_sync,
  input  logic              ev_xret,
  input  logic              ev_user,
  input  logic              ev_mark,
  input  logic              mark_write,
  input  logic [1:0]        mark_size,
  input  logic [DATA_W-1:0] mark_data,
  input  logic              ev_bus,
  input  logic [1:0]        bus_size,
  input  logic [DATA_W-1:0] bus_data,
  output logic [4:0]        status_code,
  output logic [3:0]        dbg_nib,
  output logic              dbg_nib_vld
);
  localparam int RUN_CW = $clog2(RUN_MAX);

  logic       rst_i_n;
  trace_ev_t  ev_in, src, hold_q, hold_n;
  logic       hold_vld_q, hold_vld_n, hold_en;
  enc_state_e st_q, st_n;
  logic [RUN_CW-1:0] run_q, run_n;
  logic [4:0] mark_q, mark_n;
  logic [4:0] code_q, code_n;
  logic [3:0] nib_q, nib_n;
  logic       vld_q, vld_n;
  logic       sh_load, sh_adv, sh_last;
  logic [3:0] sh_nib;
  logic       cont_seen;

  trace_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n)
  );

  trace_event_decode #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec (
    .cfg_branch_en(cfg_branch_en), .cfg_data_en(cfg_data_en),
    .ev_insn(ev_insn), .ev_branch(ev_branch), .br_target(br_target),
    .br_wide(br_wide), .ev_sync(ev_sync), .ev_xret(ev_xret),
    .ev_user(ev_user), .ev_mark(ev_mark), .mark_write(mark_write),
    .mark_size(mark_size), .mark_data(mark_data), .ev_bus(ev_bus),
    .bus_size(bus_size), .bus_data(bus_data), .ev_o(ev_in)
  );

  trace_nib_shift #(.W(TRC_PAY_W), .CW(TRC_CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_i_n), .load(sh_load), .load_val(src.payload),
    .load_cnt(src.nnib), .adv(sh_adv), .nib_o(sh_nib), .last_o(sh_last)
  );

  // A continuation cycle reports the same code as an idle cycle
  assign cont_seen = ev_cont;

  assign src = hold_vld_q ? hold_q : ev_in;

  always_comb begin
    st_n       = st_q;
    run_n      = run_q;
    hold_n     = hold_q;
    hold_vld_n = hold_vld_q;
    mark_n     = mark_q;
    code_n     = C_CONT;
    nib_n      = 4'h0;
    vld_n      = 1'b0;
    sh_load    = 1'b0;
    sh_adv     = 1'b0;
    unique case (st_q)
      ST_CODE: begin
        if (hold_vld_q) begin
          hold_n     = ev_in;
          hold_vld_n = ev_in.valid;
        end
        if (src.valid) begin
          if (src.seq) begin
            if (!COMPRESS) begin
              code_n = C_INSN;
            end else if (run_q == RUN_CW'(RUN_MAX - 1)) begin
              code_n = C_RUN + 5'(run_q);
              run_n  = '0;
            end else begin
              run_n = run_q + RUN_CW'(1);
            end
          end else if (run_q != '0) begin
            code_n     = C_RUN + 5'(run_q) - 5'd1;
            run_n      = '0;
            hold_n     = src;
            hold_vld_n = 1'b1;
          end else begin
            code_n = src.code;
            if (src.nnib != '0) begin
              sh_load = 1'b1;
              mark_n  = src.mark;
              st_n    = src.has_mark ? ST_MARK : ST_NIB;
            end
          end
        end else if (cont_seen) begin
          code_n = C_CONT;
        end
      end
      ST_MARK: begin
        code_n = mark_q;
        st_n   = ST_NIB;
        if (ev_in.valid && !hold_vld_q) begin
          hold_n     = ev_in;
          hold_vld_n = 1'b1;
        end
      end
      ST_NIB: begin
        vld_n  = 1'b1;
        nib_n  = sh_nib;
        sh_adv = 1'b1;
        if (sh_last) st_n = ST_CODE;
        if (ev_in.valid && !hold_vld_q) begin
          hold_n     = ev_in;
          hold_vld_n = 1'b1;
        end
      end
      default: st_n = ST_CODE;
    endcase
  end

  assign hold_en = hold_vld_n | hold_vld_q;

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      st_q       <= ST_CODE;
      run_q      <= '0;
      mark_q     <= C_CONT;
      code_q     <= C_CONT;
      nib_q      <= 4'h0;
      vld_q      <= 1'b0;
      hold_vld_q <= 1'b0;
      hold_q     <= '0;
    end else begin
      st_q       <= st_n;
      run_q      <= run_n;
      mark_q     <= mark_n;
      code_q     <= code_n;
      nib_q      <= nib_n;
      vld_q      <= vld_n;
      hold_vld_q <= hold_vld_n;
      if (hold_en) hold_q <= hold_n;
    end
  end

  assign status_code = code_q;
  assign dbg_nib     = nib_q;
  assign dbg_nib_vld = vld_q;
endmodule

// File: rtl/trace_status_encoder_chk.sv
module trace_status_encoder_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] status_code,
  input logic       dbg_nib_vld
);
  // R1
  always @(posedge clk) begin
    if (!rst_n) begin
      reset_state_chk: assert (status_code == 5'h00 && !dbg_nib_vld);
    end
  end

  // R11
  reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(status_code inside {5'h02, 5'h06, 5'h0A, 5'h0C, 5'h0F}));

  // R8
  nibble_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_nib_vld |-> status_code == 5'h00);

  // R8
  nibble_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dbg_nib_vld) |-> ($past(status_code) inside {5'h08, 5'h09, 5'h0B, 5'h0D, 5'h0E}));

  // R6
  marker_then_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status_code inside {5'h08, 5'h09, 5'h0B, 5'h0D, 5'h0E}) |=> dbg_nib_vld);
endmodule

bind trace_status_encoder trace_status_encoder_chk u_chk (.*);

// File: tb/trace_status_encoder_bench.sv
module trace_status_encoder_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_branch_en, cfg_data_en;
  logic        ev_insn, ev_cont, ev_branch, br_wide, ev_sync, ev_xret, ev_user;
  logic        ev_mark, mark_write, ev_bus;
  logic [23:0] br_target;
  logic [1:0]  mark_size, bus_size;
  logic [31:0] mark_data, bus_data;
  logic [4:0]  status_code;
  logic [3:0]  dbg_nib;
  logic        dbg_nib_vld;

  int checks = 0;
  int errors = 0;
  int reserved_seen = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  trace_status_encoder u_trace_status_encoder (
    .clk(clk), .rst_n(rst_n), .cfg_branch_en(cfg_branch_en), .cfg_data_en(cfg_data_en),
    .ev_insn(ev_insn), .ev_cont(ev_cont), .ev_branch(ev_branch), .br_target(br_target),
    .br_wide(br_wide), .ev_sync(ev_sync), .ev_xret(ev_xret), .ev_user(ev_user),
    .ev_mark(ev_mark), .mark_write(mark_write), .mark_size(mark_size),
    .mark_data(mark_data), .ev_bus(ev_bus), .bus_size(bus_size), .bus_data(bus_data),
    .status_code(status_code), .dbg_nib(dbg_nib), .dbg_nib_vld(dbg_nib_vld)
  );

  // R11: watch every sampled cycle for a reserved code
  always @(negedge clk) begin
    if (rst_n && (status_code inside {5'h02, 5'h06, 5'h0A, 5'h0C, 5'h0F}))
      reserved_seen++;
  end

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic clear_inputs();
    ev_insn = 0; ev_cont = 0; ev_branch = 0; br_wide = 0; ev_sync = 0;
    ev_xret = 0; ev_user = 0; ev_mark = 0; mark_write = 0; ev_bus = 0;
    br_target = '0; mark_size = '0; bus_size = '0; mark_data = '0; bus_data = '0;
  endtask

  task automatic chk(input logic [4:0] ec, input logic ev, input logic [3:0] en, input string r);
    checks++;
    if (status_code !== ec || dbg_nib_vld !== ev || (ev && dbg_nib !== en)) begin
      errors++;
      $display("FAIL %s: code=%h vld=%b nib=%h expected code=%h vld=%b nib=%h",
               r, status_code, dbg_nib_vld, dbg_nib, ec, ev, en);
    end
  endtask

  task automatic chk_nibbles(input logic [31:0] val, input int n, input string r);
    for (int i = 0; i < n; i++) begin
      cycle();
      chk(5'h00, 1'b1, 4'(val >> (4 * i)), r);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_branch_en = 0; cfg_data_en = 0;
    clear_inputs();
    repeat (3) @(negedge clk);
    chk(5'h00, 1'b0, 4'h0, "R1 during reset");
    rst_n = 1'b1;
    repeat (4) cycle();
    chk(5'h00, 1'b0, 4'h0, "R1 after reset");
  endtask

  task automatic t_run_flush();
    for (int i = 0; i < 10; i++) begin
      ev_insn = 1;
      cycle();
      chk(5'h00, 1'b0, 4'h0, "R2 run accumulating");
    end
    ev_insn = 0; ev_xret = 1;
    cycle();
    ev_xret = 0;
    chk(5'h19, 1'b0, 4'h0, "R3 run of ten flushed first");
    cycle();
    chk(5'h07, 1'b0, 4'h0, "R5 xret after flush");
    ev_cont = 1;
    cycle();
    ev_cont = 0;
    chk(5'h00, 1'b0, 4'h0, "R2 continuation");
  endtask

  task automatic t_run_cap();
    for (int i = 0; i < 16; i++) begin
      ev_insn = 1;
      cycle();
      if (i < 15) chk(5'h00, 1'b0, 4'h0, "R2 run below cap");
      else        chk(5'h1F, 1'b0, 4'h0, "R2 run of sixteen");
    end
    cycle();
    ev_insn = 0;
    chk(5'h00, 1'b0, 4'h0, "R2 new run of one");
    ev_user = 1;
    cycle();
    ev_user = 0;
    chk(5'h10, 1'b0, 4'h0, "R3 run of one flushed");
    cycle();
    chk(5'h03, 1'b0, 4'h0, "R5 user mode");
  endtask

  task automatic t_branch();
    cfg_branch_en = 0;
    ev_branch = 1; br_target = 24'h012345;
    cycle();
    clear_inputs();
    chk(5'h05, 1'b0, 4'h0, "R4 branch, capture off");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R4 no payload when capture off");
    cfg_branch_en = 1;
    ev_branch = 1; br_target = 24'h012345; br_wide = 0;
    cycle();
    clear_inputs();
    chk(5'h05, 1'b0, 4'h0, "R4 branch narrow");
    cycle();
    chk(5'h0D, 1'b0, 4'h0, "R4 two-byte address code");
    chk_nibbles(32'(24'h012345 >> 1) & 32'hFFFF, 4, "R8 narrow address nibbles");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R8 payload ends");
    ev_branch = 1; br_target = 24'hABCDEF; br_wide = 1;
    cycle();
    clear_inputs();
    chk(5'h05, 1'b0, 4'h0, "R4 branch wide");
    cycle();
    chk(5'h0E, 1'b0, 4'h0, "R4 three-byte address code");
    chk_nibbles(32'(24'hABCDEF >> 1), 6, "R8 wide address nibbles");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R8 payload ends");
    ev_sync = 1;
    cycle();
    ev_sync = 0;
    chk(5'h05, 1'b0, 4'h0, "R4 sync serviced");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R4 sync has no payload");
  endtask

  task automatic t_mark();
    ev_mark = 1; mark_write = 0; mark_data = 32'h12345678;
    cycle();
    clear_inputs();
    chk(5'h04, 1'b0, 4'h0, "R6 plain marker");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R6 plain marker has no payload");
    for (int s = 0; s < 4; s++) begin
      logic [4:0] code_e;
      int         nn;
      code_e = (s == 0) ? 5'h08 : (s == 1) ? 5'h09 : 5'h0B;
      nn     = (s == 0) ? 2 : (s == 1) ? 4 : 8;
      ev_mark = 1; mark_write = 1; mark_size = 2'(s); mark_data = 32'h89ABCDEF ^ 32'(s * 32'h1111);
      cycle();
      clear_inputs();
      chk(5'h04, 1'b0, 4'h0, "R6 write marker");
      cycle();
      chk(code_e, 1'b0, 4'h0, "R6 operand size code");
      chk_nibbles(32'h89ABCDEF ^ 32'(s * 32'h1111), nn, "R6 operand nibbles");
      cycle();
      chk(5'h00, 1'b0, 4'h0, "R6 payload length");
    end
  endtask

  task automatic t_bus();
    cfg_data_en = 0;
    ev_bus = 1; bus_size = 2'd1; bus_data = 32'hCAFE1234;
    cycle();
    clear_inputs();
    chk(5'h00, 1'b0, 4'h0, "R7 bus ignored when capture off");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R7 bus ignored, no payload");
    ev_user = 1;
    cycle();
    ev_user = 0;
    chk(5'h03, 1'b0, 4'h0, "R7 nothing pending after ignored bus");
    cfg_data_en = 1;
    ev_bus = 1; bus_size = 2'd2; bus_data = 32'h13579BDF;
    cycle();
    clear_inputs();
    chk(5'h0B, 1'b0, 4'h0, "R7 bus long size code");
    chk_nibbles(32'h13579BDF, 8, "R7 bus long nibbles");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R7 payload ends");
    ev_bus = 1; bus_size = 2'd0; bus_data = 32'hFFFFFF3C;
    cycle();
    clear_inputs();
    chk(5'h08, 1'b0, 4'h0, "R7 bus byte size code");
    chk_nibbles(32'h0000003C, 2, "R7 bus byte nibbles");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R7 byte payload ends");
  endtask

  task automatic t_hold();
    ev_mark = 1; mark_write = 1; mark_size = 2'd1; mark_data = 32'h0000A1B2;
    cycle();
    clear_inputs();
    chk(5'h04, 1'b0, 4'h0, "R9 marker");
    cycle();
    chk(5'h09, 1'b0, 4'h0, "R9 size code");
    cycle();
    chk(5'h00, 1'b1, 4'h2, "R9 nibble 0");
    ev_xret = 1;
    cycle();
    ev_xret = 0;
    chk(5'h00, 1'b1, 4'hB, "R9 nibble 1 while event waits");
    cycle();
    chk(5'h00, 1'b1, 4'h1, "R9 nibble 2");
    cycle();
    chk(5'h00, 1'b1, 4'hA, "R9 nibble 3");
    cycle();
    chk(5'h07, 1'b0, 4'h0, "R9 held event after payload");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R9 held event reported once");
  endtask

  task automatic t_prio();
    ev_xret = 1; ev_user = 1;
    cycle();
    clear_inputs();
    chk(5'h07, 1'b0, 4'h0, "R10 xret beats user");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R10 user dropped");
    cfg_branch_en = 0;
    ev_branch = 1; ev_insn = 1;
    cycle();
    clear_inputs();
    chk(5'h05, 1'b0, 4'h0, "R10 branch beats instruction");
    ev_user = 1;
    cycle();
    ev_user = 0;
    chk(5'h03, 1'b0, 4'h0, "R10 instruction dropped, no run pending");
    cfg_data_en = 1;
    ev_mark = 1; ev_bus = 1; bus_size = 2'd2;
    cycle();
    clear_inputs();
    chk(5'h04, 1'b0, 4'h0, "R10 marker beats bus");
    cycle();
    chk(5'h00, 1'b0, 4'h0, "R10 bus dropped");
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion within %0d cycles", WATCHDOG);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    @(negedge clk);
    t_reset();
    t_run_flush();
    t_run_cap();
    t_branch();
    t_mark();
    t_bus();
    t_hold();
    t_prio();
    checks++;
    if (reserved_seen != 0) begin
      errors++;
      $display("FAIL R11: reserved codes seen=%0d expected 0", reserved_seen);
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule